// File: doc/BRIEF.md
# Warp Memory Request Coalescer

This block takes the memory requests of one warp (an active bit, a word address and a write flag for every lane) and turns them into the smallest practical series of wide memory transactions. The transactions leave one at a time on a valid/ready stream. Each transaction carries the following fields:

- a block-aligned base address;
- a mask of the lanes it serves;
- a word offset for every lane;
- a code that tells which merging rule produced it;
- the read/write direction.

A one-cycle `done` strobe marks the moment the whole warp has been served.

Each round picks the lowest-numbered lane that is still pending and makes it the leader. Two merging rules are then tried against the leader, in this order:

1. Gather every pending lane that carries exactly the leader's address.
2. Gather every pending lane that sits in the leader's 32-word block at the word equal to its own lane index.

If neither rule collects a second lane, the leader goes out on its own. The served lanes are removed and the rounds repeat until no lane is pending. A new warp can be loaded only while the unit is idle.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, `in_ready` is 1, `tx_valid` is 0 and `done` is 0.
- R2: When at least two pending lanes share the leader's exact address and write flag, one transaction serves all of them, with `tx_kind` = 1.
- R3: The block rule is tried only when R2 does not apply. Its candidate lanes are the pending lanes with the leader's write flag, the leader's address bits above bit 4, and an address whose low 5 bits equal the low 5 bits of the lane index. If the leader is one of these lanes and at least two lanes qualify, one transaction serves all of them, with `tx_kind` = 2.
- R4: Otherwise the leader is issued alone, with `tx_kind` = 0 and exactly one bit set in `tx_mask`.
- R5: The leader is the lowest-numbered pending lane. Rounds repeat over the remaining lanes until none remain, so the transaction sequence is fully determined by the warp contents.
- R6: Inactive lanes never appear in `tx_mask`, and their addresses and write flags have no effect on the grouping.
- R7: Lanes whose write flag differs from the leader's are never merged with it. `tx_write` equals the leader's write flag.
- R8: While `tx_valid` is 1 and `tx_ready` is 0, every transaction output holds its value. Lanes leave the pending set only when a transaction is accepted.
- R9: `done` is 1 in the cycle in which the transaction serving the last pending lane is accepted, and in no other cycle of a non-empty warp. `in_ready` is 0 from the cycle after a non-empty warp is loaded until `done`, and input offered in that period is ignored.
- R10: A warp whose active mask is all zeros raises `done` in its load cycle and emits no transaction.
- R11: `tx_base` is the leader's address with its low 5 bits cleared. `tx_offs[i*5 +: 5]` holds the low 5 address bits of lane i when lane i is in `tx_mask`, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A warp is offered |
| in_ready | output | 1 | Unit idle; the warp is taken when in_valid is also 1 |
| in_mask | input | LANES | Active bit per lane |
| in_addr | input | LANES*AW | Word address per lane; lane i at bits [i*AW +: AW] |
| in_write | input | LANES | Write flag per lane |
| tx_valid | output | 1 | A transaction is presented |
| tx_ready | input | 1 | The memory side accepts the transaction |
| tx_base | output | AW | Block-aligned base word address |
| tx_mask | output | LANES | Lanes served by this transaction |
| tx_offs | output | LANES*BB | Word offset per served lane, zero elsewhere |
| tx_kind | output | 2 | 0 = single lane, 1 = same address, 2 = same block |
| tx_write | output | 1 | Direction of the transaction |
| done | output | 1 | Last pending lane served, or an empty warp was loaded |

## Verification
The assertions assume that the memory side follows the valid/ready rule, that `tx_ready` may stall for any number of cycles, and that `in_valid` may be held high while the unit is busy without anything being taken. The stimulus respects these assumptions:

- `tx_ready` is driven from a pseudo-random stream with frequent stalls.
- During some warps a different warp is held on the input on purpose.
- Addresses are drawn from small pools, so that equal addresses, shared blocks and lane-aligned words all occur often.

Under this stimulus the hold, subset and idle-after-done properties are exercised together with the grouping rules.

// File: rtl/coal_pkg.sv
package coal_pkg;

  typedef enum logic [1:0] {
    KIND_SINGLE = 2'd0,
    KIND_SAME   = 2'd1,
    KIND_BLOCK  = 2'd2
  } tx_kind_e;

  // Two word addresses lie in one block when the bits above the block offset agree.
  function automatic logic same_block(input logic [63:0] a, input logic [63:0] b,
                                      input int bb);
    return (a >> bb) == (b >> bb);
  endfunction

  // A lane is aligned when its word offset in the block equals its lane index modulo the block size.
  function automatic logic lane_aligned(input logic [63:0] a, input int lane, input int bb);
    logic [63:0] m;
    m = (64'd1 << bb) - 64'd1;
    return (a & m) == (64'(lane) & m);
  endfunction

endpackage

// File: rtl/coal_leader.sv
module coal_leader #(
  parameter int LANES = 32,
  localparam int LW = $clog2(LANES)
) (
  input  logic [LANES-1:0] pend,
  output logic [LANES-1:0] lead_oh,
  output logic [LW-1:0]    lead_idx
);
  // Isolate the lowest set bit of the pending mask.
  assign lead_oh = pend & (~pend + LANES'(1));

  always_comb begin
    lead_idx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pend[i]) lead_idx = LW'(i);
    end
  end
endmodule

// File: rtl/coal_match.sv
module coal_match
  import coal_pkg::*;
#(
  parameter int LANES = 32,
  parameter int AW    = 32,
  parameter int BB    = 5,
  localparam int LW   = $clog2(LANES)
) (
  input  logic [LANES*AW-1:0] addr,
  input  logic [LANES-1:0]    wr,
  input  logic [LANES-1:0]    pend,
  input  logic [LW-1:0]       lead_idx,
  output logic [AW-1:0]       lead_addr,
  output logic                lead_wr,
  output logic [LANES-1:0]    same_mask,
  output logic [LANES-1:0]    blk_mask
);
  assign lead_addr = addr[lead_idx*AW +: AW];
  assign lead_wr   = wr[lead_idx];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [AW-1:0] a_i;
    logic          dir_ok;
    assign a_i    = addr[i*AW +: AW];
    assign dir_ok = pend[i] && (wr[i] == lead_wr);
    assign same_mask[i] = dir_ok && (a_i == lead_addr);
    assign blk_mask[i]  = dir_ok && same_block(64'(a_i), 64'(lead_addr), BB)
                          && lane_aligned(64'(a_i), i, BB);
  end
endmodule

// File: rtl/coal_select.sv
module coal_select
  import coal_pkg::*;
#(
  parameter int LANES = 32,
  parameter int AW    = 32,
  parameter int BB    = 5
) (
  input  logic [LANES*AW-1:0] addr,
  input  logic [LANES-1:0]    same_mask,
  input  logic [LANES-1:0]    blk_mask,
  input  logic [LANES-1:0]    lead_oh,
  input  logic [AW-1:0]       lead_addr,
  output logic [LANES-1:0]    sel_mask,
  output tx_kind_e            sel_kind,
  output logic [AW-1:0]       sel_base,
  output logic [LANES*BB-1:0] sel_offs
);
  logic use_same, use_blk;
  assign use_same = $countones(same_mask) >= 2;
  assign use_blk  = ((blk_mask & lead_oh) != '0) && ($countones(blk_mask) >= 2);

  always_comb begin
    if (use_same) begin
      sel_mask = same_mask;
      sel_kind = KIND_SAME;
    end else if (use_blk) begin
      sel_mask = blk_mask;
      sel_kind = KIND_BLOCK;
    end else begin
      sel_mask = lead_oh;
      sel_kind = KIND_SINGLE;
    end
  end

  assign sel_base = {lead_addr[AW-1:BB], {BB{1'b0}}};

  for (genvar i = 0; i < LANES; i++) begin : g_off
    assign sel_offs[i*BB +: BB] = sel_mask[i] ? addr[i*AW +: BB] : '0;
  end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
  import coal_pkg::*;
#(
  parameter int LANES     = 32,
  parameter int AW        = 32,
  parameter int BLK_WORDS = 32,
  localparam int BB       = $clog2(BLK_WORDS),
  localparam int LW       = $clog2(LANES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [LANES-1:0]    in_mask,
  input  logic [LANES*AW-1:0] in_addr,
  input  logic [LANES-1:0]    in_write,
  output logic                tx_valid,
  input  logic                tx_ready,
  output logic [AW-1:0]       tx_base,
  output logic [LANES-1:0]    tx_mask,
  output logic [LANES*BB-1:0] tx_offs,
  output logic [1:0]          tx_kind,
  output logic                tx_write,
  output logic                done
);
  logic                busy_q;
  logic [LANES-1:0]    pend_q;
  logic [LANES*AW-1:0] addr_q;
  logic [LANES-1:0]    wr_q;

  // Named events for the assertions.
  logic in_fire, tx_fire, tx_last, empty_load;
  logic [LANES-1:0] pend_left;

  logic [LANES-1:0] lead_oh, same_mask, blk_mask;
  logic [LW-1:0]    lead_idx;
  logic [AW-1:0]    lead_addr;
  tx_kind_e         sel_kind;

  coal_leader #(.LANES(LANES)) u_leader (
    .pend(pend_q), .lead_oh(lead_oh), .lead_idx(lead_idx)
  );

  coal_match #(.LANES(LANES), .AW(AW), .BB(BB)) u_match (
    .addr(addr_q), .wr(wr_q), .pend(pend_q), .lead_idx(lead_idx),
    .lead_addr(lead_addr), .lead_wr(tx_write),
    .same_mask(same_mask), .blk_mask(blk_mask)
  );

  coal_select #(.LANES(LANES), .AW(AW), .BB(BB)) u_select (
    .addr(addr_q), .same_mask(same_mask), .blk_mask(blk_mask), .lead_oh(lead_oh),
    .lead_addr(lead_addr), .sel_mask(tx_mask), .sel_kind(sel_kind),
    .sel_base(tx_base), .sel_offs(tx_offs)
  );

  assign tx_kind    = sel_kind;
  assign in_ready   = !busy_q;
  assign tx_valid   = busy_q;
  assign in_fire    = in_valid && in_ready;
  assign tx_fire    = tx_valid && tx_ready;
  assign pend_left  = pend_q & ~tx_mask;
  assign tx_last    = tx_fire && (pend_left == '0);
  assign empty_load = in_fire && (in_mask == '0);
  assign done       = tx_last || empty_load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend_q <= '0;
      addr_q <= '0;
      wr_q   <= '0;
    end else if (in_fire) begin
      busy_q <= (in_mask != '0);
      pend_q <= in_mask;
      addr_q <= in_addr;
      wr_q   <= in_write;
    end else if (tx_fire) begin
      pend_q <= pend_left;
      if (tx_last) busy_q <= 1'b0;
    end
  end

  // R8: a stalled transaction holds all of its fields
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_mask) && $stable(tx_base)
                              && $stable(tx_kind) && $stable(tx_offs) && $stable(tx_write));

  // R8: pending lanes do not change without an accept
  p_pend_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> $stable(pend_q));

  // R6: only pending (hence active) lanes are served, and never none
  p_mask_subset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_mask != '0) && ((tx_mask & ~pend_q) == '0));

  // R5: the leader is always served
  p_leader_served_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_mask & lead_oh) == lead_oh);

  // R2: a merged transaction covers two or more lanes
  p_merge_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && (tx_kind != 2'd0) |-> $countones(tx_mask) >= 2);

  // R4: a single transaction covers exactly one lane
  p_single_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && (tx_kind == 2'd0) |-> $countones(tx_mask) == 1);

  // R9: after done the unit is idle
  p_idle_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> in_ready && !tx_valid);

  // R10: an empty warp leaves nothing pending
  p_empty_warp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    empty_load |=> !tx_valid && (pend_q == '0));
endmodule

// File: tb/warp_coalescer_tb.sv
module warp_coalescer_tb;
  localparam int L  = 32;
  localparam int AW = 32;
  localparam int BB = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [L-1:0] in_mask = '0;
  logic [L*AW-1:0] in_addr = '0;
  logic [L-1:0] in_write = '0;
  logic tx_valid;
  logic tx_ready = 1'b0;
  logic [AW-1:0] tx_base;
  logic [L-1:0] tx_mask;
  logic [L*BB-1:0] tx_offs;
  logic [1:0] tx_kind;
  logic tx_write;
  logic done;

  always #2.5 clk = ~clk;

  warp_coalescer u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mask(in_mask), .in_addr(in_addr), .in_write(in_write),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_base(tx_base), .tx_mask(tx_mask),
    .tx_offs(tx_offs), .tx_kind(tx_kind), .tx_write(tx_write), .done(done)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [31:0] rng = 32'h1234_5678;

  // Expected transaction list.
  logic [L-1:0]    e_mask [32];
  logic [1:0]      e_kind [32];
  logic [AW-1:0]   e_base [32];
  logic [L*BB-1:0] e_offs [32];
  logic            e_wr   [32];
  int              e_n;

  task automatic chk(input logic ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    return x ^ (x << 5);
  endfunction

  // Reference grouping computed from the requirements.
  task automatic model(input logic [L-1:0] m, input logic [L*AW-1:0] a, input logic [L-1:0] w);
    logic [L-1:0] left;
    left = m;
    e_n = 0;
    while (left != '0) begin
      int lead;
      logic [AW-1:0] la;
      logic [L-1:0] s, b, pick;
      int ns, nb;
      lead = 0;
      while (!left[lead]) lead++;
      la = a[lead*AW +: AW];
      s = '0; b = '0; ns = 0; nb = 0;
      for (int i = 0; i < L; i++) begin
        logic [AW-1:0] ai;
        ai = a[i*AW +: AW];
        if (left[i] && w[i] == w[lead]) begin
          if (ai == la) begin s[i] = 1'b1; ns++; end
          if (ai / 32 == la / 32 && ai % 32 == i % 32) begin b[i] = 1'b1; nb++; end
        end
      end
      if (ns > 1) begin pick = s; e_kind[e_n] = 2'd1; end
      else if (b[lead] && nb > 1) begin pick = b; e_kind[e_n] = 2'd2; end
      else begin pick = '0; pick[lead] = 1'b1; e_kind[e_n] = 2'd0; end
      e_mask[e_n] = pick;
      e_base[e_n] = la - (la % 32);
      e_wr[e_n]   = w[lead];
      e_offs[e_n] = '0;
      for (int i = 0; i < L; i++)
        if (pick[i]) e_offs[e_n][i*BB +: BB] = a[i*AW +: BB];
      left = left & ~pick;
      e_n++;
    end
  endtask

  task automatic run_warp(input logic [L-1:0] m, input logic [L*AW-1:0] a,
                          input logic [L-1:0] w, input logic poke);
    int k, cyc;
    logic stalled;
    logic [L-1:0] p_mask;
    logic [AW-1:0] p_base;
    logic [1:0] p_kind;
    model(m, a, w);
    @(negedge clk);
    chk(in_ready, "R9 idle before load", 256'(in_ready), 256'(1));
    in_valid = 1'b1; in_mask = m; in_addr = a; in_write = w;
    #1;
    if (m == '0) chk(done && !tx_valid, "R10 empty warp done", 256'(done), 256'(1));
    else chk(!done, "R9 no done at load", 256'(done), 256'(0));
    @(posedge clk);
    #1 in_valid = poke; in_mask = ~m; in_addr = ~a; in_write = ~w;
    k = 0; cyc = 0; stalled = 1'b0;
    p_mask = '0; p_base = '0; p_kind = '0;
    while (k < e_n && cyc < 400) begin
      @(negedge clk);
      rng = nxt(rng);
      tx_ready = (rng[1:0] != 2'b00);
      #1;
      chk(tx_valid && !in_ready, "R5 R9 busy until served", 256'(tx_valid), 256'(1));
      if (stalled)
        chk(tx_mask == p_mask && tx_base == p_base && tx_kind == p_kind, "R8 hold",
            256'(tx_mask), 256'(p_mask));
      if (tx_valid && tx_ready) begin
        chk(tx_mask == e_mask[k], "R2 R3 R4 R5 lane mask", 256'(tx_mask), 256'(e_mask[k]));
        chk((tx_mask & ~m) == '0, "R6 inactive lanes", 256'(tx_mask & ~m), 256'(0));
        chk(tx_kind == e_kind[k], "R2 R3 R4 kind", 256'(tx_kind), 256'(e_kind[k]));
        chk(tx_base == e_base[k], "R11 base", 256'(tx_base), 256'(e_base[k]));
        chk(tx_offs == e_offs[k], "R11 offsets", 256'(tx_offs), 256'(e_offs[k]));
        chk(tx_write == e_wr[k], "R7 write flag", 256'(tx_write), 256'(e_wr[k]));
        chk(done == (k == e_n - 1), "R9 done timing", 256'(done), 256'(k == e_n - 1));
        k++;
        stalled = 1'b0;
      end else begin
        chk(!done, "R9 no done while stalled", 256'(done), 256'(0));
        stalled = 1'b1;
        p_mask = tx_mask; p_base = tx_base; p_kind = tx_kind;
      end
      cyc++;
    end
    chk(cyc < 400, "R5 warp completes", 256'(cyc), 256'(400));
    @(negedge clk);
    in_valid = 1'b0; tx_ready = 1'b0;
    #1;
    chk(!tx_valid && in_ready && !done, "R9 idle after done", 256'(tx_valid), 256'(0));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected<=190000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [L*AW-1:0] a;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(in_ready && !tx_valid && !done, "R1 reset", {tx_valid, done, in_ready}, 256'b001);
    @(negedge clk) rst_n = 1'b1;

    // R2: all lanes same address
    for (int i = 0; i < L; i++) a[i*AW +: AW] = 32'h0000_4A7;
    run_warp('1, a, '0, 1'b0);
    // R3: perfectly aligned block, held input while busy (R9)
    for (int i = 0; i < L; i++) a[i*AW +: AW] = 32'h0000_0300 + 32'(i);
    run_warp('1, a, '0, 1'b1);
    // R3 with holes in the mask and some misaligned lanes
    for (int i = 0; i < L; i++) a[i*AW +: AW] = 32'h0000_0300 + 32'((i % 3 == 0) ? i + 1 : i);
    run_warp(32'hF0F0_FFF3, a, '0, 1'b0);
    // R4: scattered addresses
    for (int i = 0; i < L; i++) a[i*AW +: AW] = 32'h0001_0000 * 32'(i + 1) + 32'(i * 7);
    run_warp(32'h8001_0421, a, '0, 1'b0);
    // R6: inactive lanes share the leader address but must be ignored
    for (int i = 0; i < L; i++) a[i*AW +: AW] = (i % 2 == 0) ? 32'h55 : 32'h1000 + 32'(i * 64);
    run_warp(32'hAAAA_AAAB, a, '0, 1'b0);
    // R7: same address, mixed write flags
    for (int i = 0; i < L; i++) a[i*AW +: AW] = 32'h0000_0900;
    run_warp('1, a, 32'h0F0F_00FF, 1'b0);
    // R10: empty warp
    run_warp('0, a, '0, 1'b0);
    // single active lane
    run_warp(32'h0000_8000, a, '0, 1'b0);

    // Sweep of pseudo-random warps over small address pools
    for (int n = 0; n < 600; n++) begin
      logic [L-1:0] m, w;
      rng = nxt(rng); m = rng;
      if (n % 4 == 0) m = '1;
      rng = nxt(rng); w = (n % 3 == 0) ? (rng & nxt(rng)) : '0;
      for (int i = 0; i < L; i++) begin
        rng = nxt(rng);
        case (n % 5)
          0: a[i*AW +: AW] = 32'h40 * 32'(rng[1:0]);
          1: a[i*AW +: AW] = (rng[2:0] == 0) ? 32'h200 + 32'(rng[7:3]) : 32'h200 + 32'(i);
          2: a[i*AW +: AW] = 32'h20 * 32'(rng[0]) + 32'(rng[1] ? i : 3);
          3: a[i*AW +: AW] = 32'(rng[12:0]);
          default: a[i*AW +: AW] = rng[3] ? 32'h777 : 32'h7E0 + 32'(i);
        endcase
      end
      run_warp(m, a, w, n[0]);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule